// File: doc/BRIEF.md
# Conversion Sequencer with Automatic Power-Down

This block runs one successive-approximation conversion at a time for an analog-to-digital converter. A falling edge on the convert-start input switches the track/hold to hold and raises busy. The block then steps a 10-bit trial code for the capacitor DAC from the most significant bit down to the least, and uses the comparator bit at each step to keep or clear that bit. The conversion takes one of two fixed lengths. The longer length applies when the temperature-sensor address is selected, and the shorter one applies to every other channel.

When a conversion ends, busy falls and the track/hold goes back to track. A one-cycle strobe then presents the result together with the channel that was converted. The level of convert-start at that moment decides whether the converter stays powered. A low level powers it down. A later rising edge wakes it through a timed power-up window, and a falling edge that arrives during this window is held until power-up completes. All durations are counted in system-clock cycles. Convert-start is synchronised and filtered, so pulses shorter than a set number of cycles have no effect.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the block is powered down: pwrEn, busy, holdOn and resValid are 0 and dacCode is 0.
- R2: When the block is powered and idle, a falling convStart makes busy and holdOn both 1 on the (MIN_PULSE_CYC+3)-th rising clock edge, counting from the first edge that samples the low level, and not earlier.
- R3: Busy stays high for exactly TEMP_CYC cycles when chanAddr equals TEMP_CH (address 0) at the start, and for exactly ANA_CYC cycles for any other address. During that time holdOn equals busy and pwrEn is 1.
- R4: The first trial code of a conversion is 10'h200 (MSB only). Each step keeps the trial bit when cmpKeep is 1 and clears it when cmpKeep is 0. With a comparator that reports dacCode <= vin, the result equals vin.
- R5: resValid is 1 for exactly one cycle, the first cycle with busy low. In that cycle resData holds the result and resChan holds the address captured at the start, even if chanAddr has changed since.
- R6: If the filtered convStart level is low at the end of a conversion, pwrEn falls together with busy. If it is high, pwrEn stays 1, and the next falling edge starts a conversion with the R2 latency.
- R7: While the block is powered down, a rising convStart sets pwrEn to 1 after MIN_PULSE_CYC+3 edges. No conversion starts until pwrEn has been high for PWRUP_CYC cycles.
- R8: A falling convStart that arrives during power-up is deferred. Busy rises exactly PWRUP_CYC cycles after pwrEn rose.
- R9: A convStart pulse shorter than MIN_PULSE_CYC cycles is ignored. Such a pulse neither starts a conversion nor wakes the block.
- R10: A falling convStart during a conversion neither restarts nor shortens it.
- R11: Between conversions dacCode stays constant and equal to the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | Convert-start level, asynchronous |
| chanAddr | input | 3 | Currently selected channel address |
| cmpKeep | input | 1 | Comparator result: 1 when the input is at or above the trial code |
| busy | output | 1 | High during a conversion |
| holdOn | output | 1 | 1 = track/hold in hold, 0 = track |
| pwrEn | output | 1 | Analog power enable |
| dacCode | output | 10 | Trial code for the DAC |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | 10 | Conversion result, valid with resValid |
| resChan | output | 3 | Converted channel address, valid with resValid |

## Verification
The assertions assume that cmpKeep is settled from the current dacCode before every decision edge. The assertions also assume that PWRUP_CYC exceeds the filter latency, so a deferred start is still seen inside the power-up window. The bench meets the first assumption by modelling the comparator as a combinational compare of dacCode against a per-conversion input value. It holds convStart low or high for longer than the filter length, except for the deliberate short glitches. chanAddr is changed at arbitrary times during a conversion, which exercises the start-time capture. The bench draws random channels, input codes and end-of-conversion levels from a fixed seed, and mixes them with directed cases at full scale, zero and mid-scale.

// File: rtl/cvseq_pkg.sv
package cvseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAKE = 2'd1,
    ST_IDLE = 2'd2,
    ST_CONV = 2'd3
  } seqState_t;

  typedef struct packed {
    logic start;
    logic decide;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/cvseq_in_filter.sv
module cvseq_in_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_PULSE_CYC = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvl,
  output logic riseEvt,
  output logic fallEvt
);
  localparam int FILT_W = (MIN_PULSE_CYC > 1) ? $clog2(MIN_PULSE_CYC) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   synced;
  logic [FILT_W-1:0]      runCnt;
  logic                   lvlPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end
  assign synced = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      lvl     <= 1'b0;
      lvlPrev <= 1'b0;
    end else begin
      lvlPrev <= lvl;
      if (synced == lvl) begin
        runCnt <= '0;
      end else if (runCnt == FILT_W'(MIN_PULSE_CYC - 1)) begin
        lvl    <= synced;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + FILT_W'(1);
      end
    end
  end

  assign riseEvt = lvl & ~lvlPrev;
  assign fallEvt = ~lvl & lvlPrev;

endmodule

// File: rtl/cvseq_ctrl.sv
module cvseq_ctrl
  import cvseq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int CH_W      = 3,
  parameter int TEMP_CH   = 0,
  parameter int ANA_CYC   = 450,
  parameter int TEMP_CYC  = 1350,
  parameter int PWRUP_CYC = 100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lvl,
  input  logic            riseEvt,
  input  logic            fallEvt,
  input  logic [CH_W-1:0] chanAddr,
  output seqStrobe_t      strb,
  output logic            busy,
  output logic            pwrEn
);
  localparam int MAX_CYC   = (TEMP_CYC > ANA_CYC) ? TEMP_CYC : ANA_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC);
  localparam int ANA_STEP  = (ANA_CYC - 1) / RES_W;
  localparam int TEMP_STEP = (TEMP_CYC - 1) / RES_W;
  localparam int BIT_W     = $clog2(RES_W + 1);
  localparam int WAKE_W    = (PWRUP_CYC > 1) ? $clog2(PWRUP_CYC) : 1;

  seqState_t         state;
  logic [CNT_W-1:0]  cycCnt;
  logic [CNT_W-1:0]  stepCnt;
  logic [CNT_W-1:0]  convLast;
  logic [CNT_W-1:0]  stepLast;
  logic [BIT_W-1:0]  bitCnt;
  logic [WAKE_W-1:0] wakeCnt;
  logic              pending;
  logic              wakeDone;
  logic              startNow;
  logic              isTemp;

  assign isTemp   = (chanAddr == CH_W'(TEMP_CH));
  assign wakeDone = (wakeCnt == WAKE_W'(PWRUP_CYC - 1));
  assign startNow = ((state == ST_IDLE) && fallEvt) ||
                    ((state == ST_WAKE) && wakeDone && (pending || fallEvt));

  always_comb begin
    strb        = '0;
    strb.start  = startNow;
    strb.decide = (state == ST_CONV) && (stepCnt == stepLast) &&
                  (bitCnt != BIT_W'(RES_W));
    strb.finish = (state == ST_CONV) && (cycCnt == convLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      cycCnt   <= '0;
      stepCnt  <= '0;
      bitCnt   <= '0;
      convLast <= '0;
      stepLast <= '0;
      wakeCnt  <= '0;
      pending  <= 1'b0;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (riseEvt) begin
            state   <= ST_WAKE;
            wakeCnt <= '0;
            pending <= 1'b0;
          end
        end
        ST_WAKE: begin
          if (fallEvt) pending <= 1'b1;
          if (wakeDone) state <= (pending || fallEvt) ? ST_CONV : ST_IDLE;
          else          wakeCnt <= wakeCnt + WAKE_W'(1);
        end
        ST_IDLE: begin
          if (fallEvt) state <= ST_CONV;
        end
        ST_CONV: begin
          if (strb.finish) begin
            state <= lvl ? ST_IDLE : ST_OFF;
          end else begin
            cycCnt <= cycCnt + CNT_W'(1);
          end
          if (stepCnt == stepLast) begin
            stepCnt <= '0;
            if (bitCnt != BIT_W'(RES_W)) bitCnt <= bitCnt + BIT_W'(1);
          end else begin
            stepCnt <= stepCnt + CNT_W'(1);
          end
        end
        default: state <= ST_OFF;
      endcase
      if (startNow) begin
        cycCnt   <= '0;
        stepCnt  <= '0;
        bitCnt   <= '0;
        pending  <= 1'b0;
        convLast <= isTemp ? CNT_W'(TEMP_CYC - 1)  : CNT_W'(ANA_CYC - 1);
        stepLast <= isTemp ? CNT_W'(TEMP_STEP - 1) : CNT_W'(ANA_STEP - 1);
      end
    end
  end

  assign busy  = (state == ST_CONV);
  assign pwrEn = (state != ST_OFF);

endmodule

// File: rtl/cvseq_sar.sv
module cvseq_sar
  import cvseq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             cmpKeep,
  input  logic [CH_W-1:0]  chanAddr,
  output logic [RES_W-1:0] dacCode,
  output logic             holdOn,
  output logic             resValid,
  output logic [RES_W-1:0] resData,
  output logic [CH_W-1:0]  resChan
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] mask;
  logic [RES_W-1:0] accNext;

  assign accNext = (strb.decide && cmpKeep) ? (acc | mask) : acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      mask     <= '0;
      holdOn   <= 1'b0;
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= '0;
    end else begin
      resValid <= 1'b0;
      if (strb.start) begin
        acc     <= '0;
        mask    <= MSB_ONLY;
        resChan <= chanAddr;
        holdOn  <= 1'b1;
      end else begin
        acc <= accNext;
        if (strb.decide) mask <= mask >> 1;
        if (strb.finish) begin
          holdOn   <= 1'b0;
          resValid <= 1'b1;
          resData  <= accNext;
        end
      end
    end
  end

  assign dacCode = acc | mask;

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import cvseq_pkg::*;
#(
  parameter int RES_W         = 10,
  parameter int CH_W          = 3,
  parameter int TEMP_CH       = 0,
  parameter int ANA_CYC       = 450,
  parameter int TEMP_CYC      = 1350,
  parameter int PWRUP_CYC     = 100,
  parameter int MIN_PULSE_CYC = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic [CH_W-1:0]  chanAddr,
  input  logic             cmpKeep,
  output logic             busy,
  output logic             holdOn,
  output logic             pwrEn,
  output logic [RES_W-1:0] dacCode,
  output logic             resValid,
  output logic [RES_W-1:0] resData,
  output logic [CH_W-1:0]  resChan
);
  logic       lvl;
  logic       riseEvt;
  logic       fallEvt;
  seqStrobe_t strb;

  cvseq_in_filter #(
    .SYNC_STAGES  (SYNC_STAGES),
    .MIN_PULSE_CYC(MIN_PULSE_CYC)
  ) uFilt (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (convStart),
    .lvl    (lvl),
    .riseEvt(riseEvt),
    .fallEvt(fallEvt)
  );

  cvseq_ctrl #(
    .RES_W    (RES_W),
    .CH_W     (CH_W),
    .TEMP_CH  (TEMP_CH),
    .ANA_CYC  (ANA_CYC),
    .TEMP_CYC (TEMP_CYC),
    .PWRUP_CYC(PWRUP_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .lvl     (lvl),
    .riseEvt (riseEvt),
    .fallEvt (fallEvt),
    .chanAddr(chanAddr),
    .strb    (strb),
    .busy    (busy),
    .pwrEn   (pwrEn)
  );

  cvseq_sar #(
    .RES_W(RES_W),
    .CH_W (CH_W)
  ) uSar (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmpKeep (cmpKeep),
    .chanAddr(chanAddr),
    .dacCode (dacCode),
    .holdOn  (holdOn),
    .resValid(resValid),
    .resData (resData),
    .resChan (resChan)
  );

endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int RES_W     = 10,
  parameter int CH_W      = 3,
  parameter int TEMP_CH   = 0,
  parameter int ANA_CYC   = 450,
  parameter int TEMP_CYC  = 1350,
  parameter int PWRUP_CYC = 100
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             holdOn,
  input logic             pwrEn,
  input logic [RES_W-1:0] dacCode,
  input logic             resValid,
  input logic [CH_W-1:0]  resChan
);
  int busyLen;
  int pwrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen <= 0;
      pwrCnt  <= 0;
    end else begin
      busyLen <= busy ? busyLen + 1 : 0;
      if (!pwrEn)                 pwrCnt <= 0;
      else if (pwrCnt < PWRUP_CYC) pwrCnt <= pwrCnt + 1;
    end
  end

  AST_HOLD_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    holdOn == busy);  // R3

  AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> pwrEn);  // R3

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (busyLen == ((resChan == CH_W'(TEMP_CH)) ? TEMP_CYC : ANA_CYC)));  // R3

  AST_VALID_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $fell(busy));  // R5

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);  // R5

  AST_WAKE_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (pwrCnt >= PWRUP_CYC));  // R7

  AST_CODE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(dacCode));  // R11

endmodule

bind conv_sequencer conv_sequencer_chk #(
  .RES_W    (RES_W),
  .CH_W     (CH_W),
  .TEMP_CH  (TEMP_CH),
  .ANA_CYC  (ANA_CYC),
  .TEMP_CYC (TEMP_CYC),
  .PWRUP_CYC(PWRUP_CYC)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .holdOn  (holdOn),
  .pwrEn   (pwrEn),
  .dacCode (dacCode),
  .resValid(resValid),
  .resChan (resChan)
);

// File: tb/tb_conv_sequencer.sv
`timescale 1ns/1ps
module tb_conv_sequencer;
  localparam int M   = 2;
  localparam int P   = 8;
  localparam int ANA = 30;
  localparam int TMP = 50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convStart = 1'b0;
  logic [2:0] chanAddr = 3'd0;
  logic       cmpKeep;
  logic       busy, holdOn, pwrEn, resValid;
  logic [9:0] dacCode, resData;
  logic [2:0] resChan;
  logic [9:0] vinModel = 10'd0;

  int checks = 0;
  int fails  = 0;
  bit powered = 1'b0;

  always #10 clk = ~clk;

  assign cmpKeep = (dacCode <= vinModel);

  conv_sequencer #(
    .ANA_CYC(ANA), .TEMP_CYC(TMP), .PWRUP_CYC(P), .MIN_PULSE_CYC(M)
  ) dut (
    .clk(clk), .rstN(rstN), .convStart(convStart), .chanAddr(chanAddr),
    .cmpKeep(cmpKeep), .busy(busy), .holdOn(holdOn), .pwrEn(pwrEn),
    .dacCode(dacCode), .resValid(resValid), .resData(resData), .resChan(resChan)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input logic [2:0] ch);
    return (ch == 3'd0) ? TMP : ANA;
  endfunction

  task automatic startFromIdle();
    int cnt = 0;
    convStart = 1'b0;
    while (!busy && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk("R2 start latency", cnt, M + 3);
    chk("R2 hold at start", holdOn, 1);
  endtask

  task automatic wakeUp(input bit deferred);
    int cnt = 0;
    convStart = 1'b1;
    while (!pwrEn && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk("R7 wake latency", cnt, M + 3);
    if (deferred) begin
      convStart = 1'b0;
      repeat (P - 1) @(negedge clk);
      chk("R8 no early start", busy, 0);
      @(negedge clk);
      chk("R8 deferred start", busy, 1);
    end else begin
      repeat (P + 2) @(negedge clk);
      chk("R7 idle after wake busy", busy, 0);
      chk("R7 idle after wake pwr", pwrEn, 1);
      startFromIdle();
    end
  endtask

  task automatic finishConv(input logic [2:0] ch, input bit keepHigh, input bit glitchMid);
    int cnt = 1;
    chk("R4 first trial", dacCode, 10'h200);
    if (keepHigh) convStart = 1'b1;
    while (cnt < 2000) begin
      @(negedge clk);
      if (cnt == 3) chanAddr = ~ch;
      if (glitchMid && cnt == 10) convStart = 1'b0;
      if (glitchMid && cnt == 14) convStart = 1'b1;
      if (!busy) break;
      cnt++;
    end
    chk("R3 busy length", cnt, expLen(ch));
    chk("R3 hold released", holdOn, 0);
    chk("R5 valid strobe", resValid, 1);
    chk("R4 result", resData, vinModel);
    chk("R5 channel", resChan, ch);
    chk("R6 power after end", pwrEn, keepHigh);
    @(negedge clk);
    chk("R5 valid one cycle", resValid, 0);
    chk("R11 code held", dacCode, vinModel);
    powered = keepHigh;
  endtask

  task automatic runConv(input logic [2:0] ch, input logic [9:0] vin,
                         input bit keepHigh, input bit deferred, input bit glitchMid);
    chanAddr = ch;
    vinModel = vin;
    if (!powered) wakeUp(deferred);
    else          startFromIdle();
    finishConv(ch, keepHigh, glitchMid);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("R3 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk("R1 pwrEn", pwrEn, 0);
    chk("R1 busy", busy, 0);
    chk("R1 holdOn", holdOn, 0);
    chk("R1 resValid", resValid, 0);
    chk("R1 dacCode", dacCode, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R9: short high pulse while powered down must not wake
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    seen = 0;
    repeat (12) begin
      @(negedge clk);
      if (pwrEn) seen = 1;
    end
    chk("R9 glitch no wake", seen, 0);

    runConv(3'd0, 10'h3FF, 1'b1, 1'b0, 1'b0);

    // R9: short low pulse while idle must not start
    convStart = 1'b0;
    @(negedge clk);
    convStart = 1'b1;
    seen = 0;
    repeat (12) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    chk("R9 glitch no start", seen, 0);
    chk("R9 still powered", pwrEn, 1);

    // R10: a real falling edge in mid conversion is ignored
    runConv(3'd5, 10'h000, 1'b1, 1'b0, 1'b1);
    runConv(3'd7, 10'h200, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R11 code held off", dacCode, 10'h200);
    runConv(3'd0, 10'h155, 1'b0, 1'b1, 1'b0);
    runConv(3'd2, 10'h2AA, 1'b1, 1'b1, 1'b0);

    for (int i = 0; i < 24; i++) begin
      logic [2:0] ch;
      logic [9:0] vin;
      bit kh, df, gm;
      ch  = 3'($urandom_range(0, 7));
      vin = 10'($urandom_range(0, 1023));
      kh  = 1'($urandom_range(0, 1));
      df  = 1'($urandom_range(0, 1));
      gm  = kh && (1'($urandom_range(0, 1)));
      runConv(ch, vin, kh, df, gm);
      repeat (1 + $urandom_range(0, 4)) @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule